// File: doc/BRIEF.md
# Branch History Trace Message Serializer

This block turns one branch-history trace record into a serial bit stream. A request carries a 4-bit source tag, a sequence count, a full target address and a branch history word. The block prepends a fixed 6-bit message kind code and drops the leading zeros of the three variable fields. It then sends the resulting 13 to 82 bits out two at a time, earliest bit first.

Each output beat has two lanes. Lane 0 carries the earlier bit of the beat. A per-lane end flag marks the bit that closes each variable field, so a receiver can find the field boundaries without knowing the field lengths. An end-of-message flag marks the final beat.

Toward the upstream queue the block has a ready/valid pair. A record is taken only while the block is idle. The output side has a valid strobe and cannot be stalled.

Top module: `trace_hist_packer`

## Requirements
- R1: The first six bits of every message form the kind code 011101, taken least significant bit first: stream bits 0..5 read 1,0,1,1,1,0.
- R2: Stream bits 6..9 carry the 4-bit source tag, least significant bit first.
- R3: The sequence count, target address and history fields are each sent up to and including their most significant 1 bit, least significant bit first.
- R4: A variable field whose value is zero is sent as a single 0 bit, so a record with all fields zero gives a 13-bit message.
- R5: Fields follow one another with no gap, in this order: kind code, source, sequence count, target address, history.
- R6: A message of N bits, with N between 13 and 82, takes ceil(N/2) consecutive beats with out_valid high.
- R7: out_data[0] carries stream bit 2k and out_data[1] carries stream bit 2k+1 on beat k. When N is odd, the unused upper lane of the last beat is 0.
- R8: out_eof[i] is 1 exactly on the lane that carries the last bit of the sequence count, address or history field, and is 0 everywhere else.
- R9: out_eom is 1 on the final beat of a message only. While out_valid is low, out_eom and out_eof are 0.
- R10: req_ready is low from the cycle after a record is accepted until the cycle after its final beat. A request raised while req_ready is low is ignored and does not change the stream.
- R11: A synchronous active-high rst discards any partial message and returns the block to idle, with req_ready high and out_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Upstream record present |
| req_ready | output | 1 | Block idle and able to take a record |
| req_src | input | 4 | Source tag |
| req_seq | input | 8 | Sequence count |
| req_addr | input | 32 | Full target address |
| req_hist | input | 32 | Branch history word |
| out_valid | output | 1 | A beat is present on out_data |
| out_data | output | 2 | Two stream bits, lane 0 earlier |
| out_eof | output | 2 | Per-lane end-of-field marker |
| out_eom | output | 1 | Final beat of the message |

## Verification
Two field boundaries can land in one beat. Two coincidences are checked. In the first, one-bit sequence and address fields both end in beat 5, so both out_eof lanes rise together. In the second, the close of the history field shares the final beat with out_eom. The bench builds expected bit streams and end-marker maps from the field rules and compares them lane by lane. A request held during a busy beat and a reset in the middle of a message are also applied, and the stream and idle state that follow are judged at the ports.

// File: rtl/thp_pkg.sv
package thp_pkg;

    localparam int TC_W   = 6;
    localparam logic [TC_W-1:0] TCODE = 6'b011101;
    localparam int SRC_W  = 4;
    localparam int SEQ_W  = 8;
    localparam int ADDR_W = 32;
    localparam int HIST_W = 32;
    localparam int HDR_W  = TC_W + SRC_W;
    localparam int MSG_W  = HDR_W + SEQ_W + ADDR_W + HIST_W;
    localparam int LEN_W  = $clog2(MSG_W + 1);
    localparam int LANES  = 2;

    typedef struct packed {
        logic [SRC_W-1:0]  src;
        logic [SEQ_W-1:0]  seq;
        logic [ADDR_W-1:0] addr;
        logic [HIST_W-1:0] hist;
    } req_fields_t;

    typedef struct packed {
        logic [LEN_W-1:0] seq_len;
        logic [LEN_W-1:0] addr_len;
        logic [LEN_W-1:0] hist_len;
    } field_lens_t;

    typedef struct packed {
        logic [MSG_W-1:0] bits;
        logic [MSG_W-1:0] ends;
        logic [LEN_W-1:0] total;
    } frame_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } pk_state_e;

endpackage

// File: rtl/thp_sig_sizer.sv
module thp_sig_sizer #(
    parameter int W = 8
) (
    input  logic [W-1:0]               val,
    output logic [thp_pkg::LEN_W-1:0] len
);
    import thp_pkg::*;

    // Length is the position of the highest set bit plus one, minimum one.
    always_comb begin
        len = LEN_W'(1);
        for (int i = 0; i < W; i++) begin
            if (val[i]) begin
                len = LEN_W'(i + 1);
            end
        end
    end

endmodule

// File: rtl/thp_assembler.sv
module thp_assembler (
    input  thp_pkg::req_fields_t fields,
    input  thp_pkg::field_lens_t lens,
    output thp_pkg::frame_t      frame
);
    import thp_pkg::*;

    logic [LEN_W-1:0] off_addr;
    logic [LEN_W-1:0] off_hist;
    logic [LEN_W-1:0] total;
    logic [MSG_W-1:0] one;

    always_comb begin
        one      = MSG_W'(1);
        off_addr = LEN_W'(HDR_W) + lens.seq_len;
        off_hist = off_addr + lens.addr_len;
        total    = off_hist + lens.hist_len;

        // Trimmed fields hold zeros above their top set bit, so plain OR of
        // shifted copies concatenates them.
        frame.bits = MSG_W'(TCODE)
                   | (MSG_W'(fields.src)  << TC_W)
                   | (MSG_W'(fields.seq)  << HDR_W)
                   | (MSG_W'(fields.addr) << off_addr)
                   | (MSG_W'(fields.hist) << off_hist);

        frame.ends = (one << (off_addr - LEN_W'(1)))
                   | (one << (off_hist - LEN_W'(1)))
                   | (one << (total    - LEN_W'(1)));

        frame.total = total;
    end

endmodule

// File: rtl/thp_shifter.sv
module thp_shifter (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  thp_pkg::frame_t          frame,
    output logic                     busy,
    output logic [thp_pkg::LANES-1:0] lane_data,
    output logic [thp_pkg::LANES-1:0] lane_end,
    output logic                     last
);
    import thp_pkg::*;

    pk_state_e         state_q;
    logic [MSG_W-1:0]  bits_q;
    logic [MSG_W-1:0]  ends_q;
    logic [LEN_W-1:0]  rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            bits_q  <= '0;
            ends_q  <= '0;
            rem_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (load) begin
                        bits_q  <= frame.bits;
                        ends_q  <= frame.ends;
                        rem_q   <= frame.total;
                        state_q <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    bits_q <= bits_q >> LANES;
                    ends_q <= ends_q >> LANES;
                    if (rem_q <= LEN_W'(LANES)) begin
                        rem_q   <= '0;
                        state_q <= ST_IDLE;
                    end else begin
                        rem_q <= rem_q - LEN_W'(LANES);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q == ST_SEND);
    assign last = busy && (rem_q <= LEN_W'(LANES));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_data[g] = busy & bits_q[g];
        assign lane_end[g]  = busy & ends_q[g];
    end

endmodule

// File: rtl/trace_hist_packer.sv
module trace_hist_packer (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [3:0]  req_src,
    input  logic [7:0]  req_seq,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_hist,
    output logic        out_valid,
    output logic [1:0]  out_data,
    output logic [1:0]  out_eof,
    output logic        out_eom
);
    import thp_pkg::*;

    req_fields_t fields;
    field_lens_t lens;
    frame_t      frame;
    logic        busy;
    logic        load;

    assign fields.src  = req_src;
    assign fields.seq  = req_seq;
    assign fields.addr = req_addr;
    assign fields.hist = req_hist;

    thp_sig_sizer #(.W(SEQ_W)) u_seq_len (
        .val (fields.seq),
        .len (lens.seq_len)
    );

    thp_sig_sizer #(.W(ADDR_W)) u_addr_len (
        .val (fields.addr),
        .len (lens.addr_len)
    );

    thp_sig_sizer #(.W(HIST_W)) u_hist_len (
        .val (fields.hist),
        .len (lens.hist_len)
    );

    thp_assembler u_asm (
        .fields (fields),
        .lens   (lens),
        .frame  (frame)
    );

    assign req_ready = ~busy;
    assign load      = req_valid & req_ready;

    thp_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .frame     (frame),
        .busy      (busy),
        .lane_data (out_data),
        .lane_end  (out_eof),
        .last      (out_eom)
    );

    assign out_valid = busy;

endmodule

// File: rtl/trace_hist_packer_chk.sv
module trace_hist_packer_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic       out_valid,
    input logic [1:0] out_data,
    input logic [1:0] out_eof,
    input logic       out_eom
);

    // R10
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !req_ready);

    // R10
    accept_starts_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> out_valid);

    // R9
    eom_ends_chk: assert property (@(posedge clk) disable iff (rst)
        out_eom |=> (!out_valid && req_ready));

    // R8
    eom_marks_field_chk: assert property (@(posedge clk) disable iff (rst)
        out_eom |-> (out_eof != 2'b00));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_eof == 2'b00 && !out_eom && out_data == 2'b00));

    // R6
    no_early_stop_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(out_valid) && !$past(rst)) |-> $past(out_eom));

    // R11
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (req_ready && !out_valid));

endmodule

bind trace_hist_packer trace_hist_packer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_eof   (out_eof),
    .out_eom   (out_eom)
);

// File: tb/tb_trace_hist_packer.sv
module tb_trace_hist_packer;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [3:0]  req_src;
    logic [7:0]  req_seq;
    logic [31:0] req_addr;
    logic [31:0] req_hist;
    logic        out_valid;
    logic [1:0]  out_data;
    logic [1:0]  out_eof;
    logic        out_eom;

    always #5 clk = ~clk;

    trace_hist_packer dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_src   (req_src),
        .req_seq   (req_seq),
        .req_addr  (req_addr),
        .req_hist  (req_hist),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_eof   (out_eof),
        .out_eom   (out_eom)
    );

    // {src, seq, addr, hist} and the expected message length in bits
    localparam int NV = 8;
    localparam logic [75:0] VEC [NV] = '{
        {4'h0, 8'h00, 32'h0000_0000, 32'h0000_0000},
        {4'hF, 8'hFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {4'h5, 8'h01, 32'h0000_0001, 32'h0000_0001},
        {4'hA, 8'h03, 32'h0000_1000, 32'h0000_0005},
        {4'h3, 8'h80, 32'h8000_0000, 32'h0000_0001},
        {4'h9, 8'h2A, 32'h00AB_CDEF, 32'h0000_FFFF},
        {4'h1, 8'h00, 32'h1234_5678, 32'h8000_0001},
        {4'h0, 8'h7F, 32'h0000_0002, 32'h0000_0000}
    };
    localparam int VLEN [NV] = '{13, 82, 13, 28, 51, 56, 72, 20};

    int total = 0;
    int fails = 0;

    logic [127:0] exp_bits, exp_ends, got_bits, got_ends;
    int exp_n, beats, eom_cnt, eom_beat;
    bit ready_bad;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] val, input int n, input bit mark);
        for (int i = 0; i < n; i++) begin
            exp_bits[exp_n] = val[i];
            exp_n++;
        end
        if (mark) exp_ends[exp_n-1] = 1'b1;
    endtask

    function automatic int sig_len(input logic [31:0] val, input int w);
        int l = 1;
        for (int i = 0; i < w; i++) if (val[i]) l = i + 1;
        return l;
    endfunction

    task automatic build(input logic [75:0] v);
        exp_bits = '0;
        exp_ends = '0;
        exp_n = 0;
        push(32'b011101, 6, 1'b0);
        push(32'(v[75:72]), 4, 1'b0);
        push(32'(v[71:64]), sig_len(32'(v[71:64]), 8), 1'b1);
        push(v[63:32], sig_len(v[63:32], 32), 1'b1);
        push(v[31:0], sig_len(v[31:0], 32), 1'b1);
    endtask

    task automatic drive(input logic [75:0] v);
        {req_src, req_seq, req_addr, req_hist} = v;
    endtask

    // Called at a negedge right after acceptance; returns at the negedge after the last beat.
    task automatic collect(input bit poke);
        beats = 0; eom_cnt = 0; eom_beat = -1; ready_bad = 0;
        got_bits = '0; got_ends = '0;
        while (out_valid && beats < 64) begin
            got_bits[2*beats]   = out_data[0];
            got_bits[2*beats+1] = out_data[1];
            got_ends[2*beats]   = out_eof[0];
            got_ends[2*beats+1] = out_eof[1];
            if (out_eom) begin eom_cnt++; eom_beat = beats; end
            if (req_ready) ready_bad = 1;
            if (poke && beats == 3) begin
                req_valid = 1'b1;
                drive(VEC[1]);
            end else begin
                req_valid = 1'b0;
            end
            beats++;
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    task automatic run_vec(input int idx, input bit poke);
        logic [75:0] v = VEC[idx];
        build(v);
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", $sformatf("v%0d ready before request", idx), 128'(req_ready), 128'(1));
        req_valid = 1'b1;
        drive(v);
        @(negedge clk);
        req_valid = 1'b0;
        collect(poke);
        chk(exp_n == VLEN[idx] && beats == (VLEN[idx] + 1) / 2, "R6",
            $sformatf("v%0d beat count", idx), 128'(beats), 128'((VLEN[idx] + 1) / 2));
        chk(got_bits[5:0] == 6'b011101, "R1", $sformatf("v%0d kind code", idx),
            128'(got_bits[5:0]), 128'(6'b011101));
        chk(got_bits[9:6] == v[75:72], "R2", $sformatf("v%0d source", idx),
            128'(got_bits[9:6]), 128'(v[75:72]));
        chk(got_bits == exp_bits, "R3 R5 R7", $sformatf("v%0d stream", idx), got_bits, exp_bits);
        chk(got_ends == exp_ends, "R8", $sformatf("v%0d field ends", idx), got_ends, exp_ends);
        chk(eom_cnt == 1 && eom_beat == beats - 1, "R9", $sformatf("v%0d eom beat", idx),
            128'(eom_beat), 128'(beats - 1));
        chk(!ready_bad, "R10", $sformatf("v%0d ready low while sending", idx), 128'(ready_bad), 128'(0));
        chk(req_ready && !out_valid, "R10", $sformatf("v%0d idle after last beat", idx),
            128'({req_ready, out_valid}), 128'(2'b10));
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1;
        req_valid = 1'b0;
        drive('0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(req_ready && !out_valid && !out_eom && out_eof == 2'b00, "R11", "reset state",
            128'({req_ready, out_valid, out_eom, out_eof}), 128'(5'b10000));

        for (int i = 0; i < NV; i++) run_vec(i, 1'b0);

        // R4: all-zero record is 13 bits, 7 beats
        run_vec(0, 1'b0);
        chk(beats == 7 && got_bits[12:10] == 3'b000 && got_ends[12:10] == 3'b111, "R4",
            "zero fields one bit each", 128'({beats[7:0], got_ends[12:10]}), 128'({8'd7, 3'b111}));

        // R8: seq and addr end together in beat 5
        run_vec(2, 1'b0);
        chk(got_ends[11:10] == 2'b11, "R8", "two ends in one beat", 128'(got_ends[11:10]), 128'(2'b11));

        // R10: request held during busy beat is ignored
        run_vec(3, 1'b1);
        repeat (3) begin
            chk(!out_valid, "R10", "busy request not taken", 128'(out_valid), 128'(0));
            @(negedge clk);
        end

        // R11: reset in mid-message discards it
        @(negedge clk);
        req_valid = 1'b1;
        drive(VEC[1]);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(req_ready && !out_valid, "R11", "mid-message reset idle",
            128'({req_ready, out_valid}), 128'(2'b10));
        run_vec(5, 1'b0);

        summary();
        $finish;
    end

endmodule